// File: doc/BRIEF.md
# Corner-Turning Shift Buffer for Row-Column Transforms

This block sits between the row pass and the column pass of a separable 2-D block transform and performs the corner turn between them. It holds a square grid of data words. Each cycle it takes in one finished line from the row pass and gives out one column to the column pass. The block edge N is 2, 4 or 8 and is picked by a mode input. The grid has no second bank. It shifts either vertically or horizontally, and it reverses its axis after every N cycles. The line entering in a cycle therefore takes the place of the column leaving in that same cycle, and one set of registers carries both the block being read and the block being written.

After reset or a flush, the block waits a short, mode-dependent hold-off while the upstream row pipeline fills. It then captures one line on every clock edge without stalling. After the first N lines, the output is a steady stream of transposed columns. Block b leaves during the N cycles in which block b+1 enters. In the smaller modes only the top-left N×N corner of the grid is used.

Top module: `tpose_shift_buf`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and every lane of col_o is 0.
- R2: The mode is sampled on the first clock edge after reset or flush. The hold-off is then 1, 3 or 4 edges for N = 2, 4 or 8, counting that first edge. The next edge captures line 0 of block 0 from lanes 0..N-1 of row_i.
- R3: valid_o is 0 until N lines have been captured. It is 1 in the cycle after the Nth capture and stays 1 while lines keep arriving.
- R4: When valid_o is 1 and the current block has k lines captured so far (0 ≤ k < N), lane i of col_o (i < N) equals element k of line i of the previous complete block. Columns therefore leave in the order 0..N-1, one per cycle.
- R5: Blocks follow each other with no gap. The grid reverses its shift axis after every N captures, the first block being loaded vertically, and each later block is transposed correctly.
- R6: Lanes N..7 of col_o are always 0, and data on lanes N..7 of row_i never reaches the output.
- R7: After the sampling edge, a change on mode_i has no effect until the next reset or flush.
- R8: A clock edge with flush_i high returns the block to idle. On the next cycle valid_o is 0 and col_o is 0, and the block restarts with the hold-off of R2.
- R9: The mode encoding is 2'b00 for N = 2, 2'b01 for N = 4, and both 2'b10 and 2'b11 for N = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous return to idle |
| mode_i | input | 2 | Block size select, sampled in idle |
| row_i | input | 128 | One line from the row pass, lane k in bits 16k+15:16k |
| col_o | output | 128 | One transposed column, lane k in bits 16k+15:16k |
| valid_o | output | 1 | col_o carries a column of a complete block |

## Verification
The assertions take for granted that the row pass delivers a fresh line on every edge once the hold-off ends, since there is no stall input. They also take for granted that flush_i is a synchronous, single-cycle request. The direction and lock properties assume that mode_i matters only on the idle edge. The stimulus drives a new random line on every cycle with no gaps, including random data on the unused lanes, and raises flush only for single cycles. It changes mode_i mid-stream only to show that such a change is ignored.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
  localparam logic [1:0] MODE_N2 = 2'b00;
  localparam logic [1:0] MODE_N4 = 2'b01;
  localparam logic [1:0] MODE_N8 = 2'b10;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_HOLD = 2'd1, ST_RUN = 2'd2} tpb_state_e;
  typedef enum logic {DIR_VERT = 1'b0, DIR_HORZ = 1'b1} tpb_dir_e;
endpackage

// File: rtl/tpb_ctrl.sv
module tpb_ctrl
  import tpb_pkg::*;
#(
  parameter int MAXN    = 8,
  parameter int HOLD_N2 = 1,
  parameter int HOLD_N4 = 3,
  parameter int HOLD_N8 = 4,
  localparam int CW     = $clog2(MAXN)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic [1:0]  mode_i,
  output logic [CW:0] n_o,
  output logic        we_o,
  output logic        dir_o,
  output logic        filled_o
);
  localparam int HMAX = (HOLD_N8 > HOLD_N4) ? ((HOLD_N8 > HOLD_N2) ? HOLD_N8 : HOLD_N2)
                                            : ((HOLD_N4 > HOLD_N2) ? HOLD_N4 : HOLD_N2);
  localparam int HW   = $clog2(HMAX + 1);

  function automatic logic [HW-1:0] hold_of(input logic [1:0] m);
    case (m)
      MODE_N2: hold_of = HW'(HOLD_N2);
      MODE_N4: hold_of = HW'(HOLD_N4);
      default: hold_of = HW'(HOLD_N8);
    endcase
  endfunction

  function automatic logic [CW:0] size_of(input logic [1:0] m);
    case (m)
      MODE_N2: size_of = (CW+1)'(2);
      MODE_N4: size_of = (CW+1)'(4);
      default: size_of = (CW+1)'(MAXN);
    endcase
  endfunction

  tpb_state_e    state_q;
  tpb_dir_e      dir_q;
  logic [1:0]    mode_q;
  logic [HW-1:0] hcnt_q;
  logic [CW-1:0] pcnt_q;
  logic          filled_q;
  logic          last_line;

  assign n_o       = size_of(mode_q);
  assign last_line = ({1'b0, pcnt_q} == (n_o - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      dir_q    <= DIR_VERT;
      mode_q   <= MODE_N8;
      hcnt_q   <= '0;
      pcnt_q   <= '0;
      filled_q <= 1'b0;
    end else if (flush_i) begin
      state_q  <= ST_IDLE;
      dir_q    <= DIR_VERT;
      hcnt_q   <= '0;
      pcnt_q   <= '0;
      filled_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          mode_q <= mode_i;
          hcnt_q <= HW'(1);
          state_q <= (hold_of(mode_i) <= HW'(1)) ? ST_RUN : ST_HOLD;
        end
        ST_HOLD: begin
          hcnt_q <= hcnt_q + 1'b1;
          if (hcnt_q == hold_of(mode_q) - 1'b1) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (last_line) begin
            pcnt_q   <= '0;
            dir_q    <= (dir_q == DIR_VERT) ? DIR_HORZ : DIR_VERT;
            filled_q <= 1'b1;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign we_o     = (state_q == ST_RUN);
  assign dir_o    = dir_q;
  assign filled_o = filled_q;

  // R5: axis reverses exactly at block boundaries
  a_r5_dir_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !flush_i && last_line) |=> (dir_q != $past(dir_q)));
  a_r5_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !flush_i && !last_line) |=> $stable(dir_q));
  // R7: latched mode cannot move outside idle
  a_r7_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !flush_i) |=> $stable(mode_q));
  // R3: output can be valid only while lines stream
  a_r3_valid_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filled_q |-> (state_q == ST_RUN));
  // R8: flush empties the buffer
  a_r8_flush_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!filled_q && state_q == ST_IDLE));
  // R2: first block always loads vertically
  a_r2_first_vert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |-> (dir_q == DIR_VERT && pcnt_q == '0));
endmodule

// File: rtl/tpb_grid.sv
module tpb_grid #(
  parameter int DW   = 16,
  parameter int MAXN = 8,
  localparam int CW  = $clog2(MAXN)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     dir_i,
  input  logic [CW:0]              n_i,
  input  logic [MAXN-1:0][DW-1:0]  line_i,
  output logic [MAXN-1:0][DW-1:0]  top_row_o,
  output logic [MAXN-1:0][DW-1:0]  left_col_o
);
  logic [DW-1:0] cell_q [MAXN][MAXN];

  for (genvar i = 0; i < MAXN; i++) begin : g_row
    for (genvar j = 0; j < MAXN; j++) begin : g_col
      localparam logic [CW:0] RI = (CW+1)'(i);
      localparam logic [CW:0] RJ = (CW+1)'(j);
      logic          in_sub;
      logic [DW-1:0] v_src, h_src;

      assign in_sub = (RI < n_i) && (RJ < n_i);

      // vertical: lines enter the bottom row, rows move up
      if (i == MAXN-1) begin : g_vlast
        assign v_src = line_i[j];
      end else begin : g_vmid
        assign v_src = (RI == n_i - 1'b1) ? line_i[j] : cell_q[i+1][j];
      end
      // horizontal: lines enter the right column, columns move left
      if (j == MAXN-1) begin : g_hlast
        assign h_src = line_i[i];
      end else begin : g_hmid
        assign h_src = (RJ == n_i - 1'b1) ? line_i[i] : cell_q[i][j+1];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              cell_q[i][j] <= '0;
        else if (we_i && in_sub)  cell_q[i][j] <= dir_i ? h_src : v_src;
      end
    end
  end

  for (genvar k = 0; k < MAXN; k++) begin : g_read
    assign top_row_o[k]  = cell_q[0][k];
    assign left_col_o[k] = cell_q[k][0];
  end
endmodule

// File: rtl/tpb_colsel.sv
module tpb_colsel #(
  parameter int DW   = 16,
  parameter int MAXN = 8,
  localparam int CW  = $clog2(MAXN)
) (
  input  logic                     dir_i,
  input  logic                     filled_i,
  input  logic [CW:0]              n_i,
  input  logic [MAXN-1:0][DW-1:0]  top_row_i,
  input  logic [MAXN-1:0][DW-1:0]  left_col_i,
  output logic [MAXN-1:0][DW-1:0]  lanes_o
);
  for (genvar k = 0; k < MAXN; k++) begin : g_lane
    localparam logic [CW:0] RK = (CW+1)'(k);
    assign lanes_o[k] = (filled_i && RK < n_i) ? (dir_i ? left_col_i[k] : top_row_i[k]) : '0;
  end
endmodule

// File: rtl/tpose_shift_buf.sv
module tpose_shift_buf #(
  parameter int DW      = 16,
  parameter int MAXN    = 8,
  parameter int HOLD_N2 = 1,
  parameter int HOLD_N4 = 3,
  parameter int HOLD_N8 = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [1:0]         mode_i,
  input  logic [MAXN*DW-1:0] row_i,
  output logic [MAXN*DW-1:0] col_o,
  output logic               valid_o
);
  localparam int CW = $clog2(MAXN);

  logic [CW:0]             n;
  logic                    we, dir, filled;
  logic [MAXN-1:0][DW-1:0] line, top_row, left_col, lanes;

  assign line = row_i;

  tpb_ctrl #(
    .MAXN(MAXN), .HOLD_N2(HOLD_N2), .HOLD_N4(HOLD_N4), .HOLD_N8(HOLD_N8)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .mode_i(mode_i),
    .n_o(n), .we_o(we), .dir_o(dir), .filled_o(filled)
  );

  tpb_grid #(.DW(DW), .MAXN(MAXN)) u_grid (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .dir_i(dir), .n_i(n),
    .line_i(line), .top_row_o(top_row), .left_col_o(left_col)
  );

  tpb_colsel #(.DW(DW), .MAXN(MAXN)) u_colsel (
    .dir_i(dir), .filled_i(filled), .n_i(n),
    .top_row_i(top_row), .left_col_i(left_col), .lanes_o(lanes)
  );

  assign col_o   = lanes;
  assign valid_o = filled;
endmodule

// File: tb/tpose_shift_buf_bench.sv
module tpose_shift_buf_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         flush_i = 1'b0;
  logic [1:0]   mode_i = 2'b10;
  logic [127:0] row_i = '0;
  logic [127:0] col_o;
  logic         valid_o;

  tpose_shift_buf u_tpose_shift_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .mode_i(mode_i),
    .row_i(row_i), .col_o(col_o), .valid_o(valid_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [15:0] lines [512][8];
  int    e_cnt = 0;   // edges since reset/flush
  int    w_cnt = 0;   // lines captured
  int    mn = 8;      // block edge
  int    md = 4;      // hold-off
  bit    prev_fl = 0;
  string ctx = "";

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic check_out();
    bit          ev;
    int          b, k;
    logic [15:0] ex, ac;
    string       vt, dt;
    ev = rst_ni && (w_cnt >= mn);
    if (!rst_ni)        vt = "R1";
    else if (prev_fl)   vt = "R8";
    else if (ctx != "") vt = ctx;
    else                vt = "R3";
    chk(valid_o === ev, vt, {15'd0, valid_o}, {15'd0, ev});
    b = ev ? (w_cnt / mn - 1) : 0;
    k = ev ? (w_cnt % mn) : 0;
    for (int ln = 0; ln < 8; ln++) begin
      ex = (ev && ln < mn) ? lines[b*mn + ln][k] : 16'h0;
      ac = col_o[ln*16 +: 16];
      if (!ev)             dt = vt;
      else if (ln >= mn)   dt = "R6";
      else if (ctx == "R9") dt = "R9";
      else if (b == 0)     dt = "R2";
      else if (b == 1)     dt = "R4";
      else                 dt = "R5";
      chk(ac === ex, dt, ac, ex);
    end
  endtask

  task automatic step(input logic rs, input logic fl, input logic [1:0] mode);
    logic [127:0] r;
    @(negedge clk_i);
    check_out();
    prev_fl = rs && fl;
    for (int q = 0; q < 4; q++) r[q*32 +: 32] = $urandom;
    rst_ni  = rs;
    flush_i = fl;
    mode_i  = mode;
    row_i   = r;
    if (!rs || fl) begin
      e_cnt = 0;
      w_cnt = 0;
    end else begin
      e_cnt++;
      if (e_cnt == 1) begin
        mn = (mode == 2'b00) ? 2 : (mode == 2'b01) ? 4 : 8;
        md = (mode == 2'b00) ? 1 : (mode == 2'b01) ? 3 : 4;
      end
      if (e_cnt > md) begin
        for (int ln = 0; ln < 8; ln++) lines[w_cnt][ln] = r[ln*16 +: 16];
        w_cnt++;
      end
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) step(1'b0, 1'b0, 2'b10);
    // 8x8 stream, R2..R5
    repeat (48) step(1'b1, 1'b0, 2'b10);
    // R8: flush mid-block, switch to 4x4
    step(1'b1, 1'b1, 2'b01);
    repeat (14) step(1'b1, 1'b0, 2'b01);
    // R7: mode_i changes are ignored while running
    ctx = "R7";
    repeat (20) step(1'b1, 1'b0, 2'b00);
    ctx = "";
    // 2x2 stream with junk on unused lanes (R6)
    step(1'b1, 1'b1, 2'b00);
    repeat (24) step(1'b1, 1'b0, 2'b00);
    // R9: code 2'b11 selects 8x8
    step(1'b1, 1'b1, 2'b11);
    ctx = "R9";
    repeat (36) step(1'b1, 1'b0, 2'b11);
    ctx = "";
    // reset in the middle of a run, restart in 4x4
    repeat (2) step(1'b0, 1'b0, 2'b01);
    repeat (16) step(1'b1, 1'b0, 2'b01);
    @(negedge clk_i);
    check_out();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule